// File: doc/BRIEF.md
# Transactional Undo Log Engine

This block gives one hardware thread eager version management for transactional memory. Inside a transaction, stores write their new values straight into a local block store. The first store to each block also appends an undo record to a log region, so committing costs one cycle and copies nothing. A small fully associative tracking table holds a read flag and a write flag for every block the transaction has touched. The write flag ensures that each block is logged only once.

Software opens a transaction with a begin command, which also supplies the byte address of the log region. It closes the transaction with commit or abort. On abort the engine holds `busy` high and replays the log from the newest record to the oldest, restoring one block per cycle. It then returns to idle with every flag cleared and the log pointer back at the base. Outside a transaction, loads and stores go straight to the block store.

The controller has three states: `ST_IDLE` (no transaction), `ST_TXN` (transaction open) and `ST_UNDO` (abort replay). The transitions are: `ST_IDLE`→`ST_TXN` on begin; `ST_TXN`→`ST_IDLE` on commit, or on abort when the log is empty; `ST_TXN`→`ST_UNDO` on abort when at least one record exists; `ST_UNDO`→`ST_UNDO` while older records remain; `ST_UNDO`→`ST_IDLE` after the oldest record has been restored.

Top module: `tul_undo_engine`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `txn_active`=0, `log_ptr`=0, `log_wr_en`=0 and `log_full_err`=0, and every block reads as zero.
- R2: Commands use `cmd_op` encoding 01=begin, 10=commit, 11=abort. A begin in idle clears all flags, loads `log_ptr` from `log_base_in` and raises `txn_active` on the next cycle. A begin while a transaction is open has no effect.
- R3: A transactional load is acknowledged in the same cycle, returns the block contents on `rsp_rdata`, marks the block as read and writes no log record.
- R4: The first transactional store to a block emits one log record on the cycle after acceptance. The record carries `log_wr_addr` equal to the old pointer, `log_wr_tag` equal to the block index and `log_wr_old` equal to the previous contents. The pointer advances by REC_BYTES (0x48 by default), and the block takes the new data in place.
- R5: A store to a block whose write flag is already set updates the block but emits no record and leaves `log_ptr` unchanged.
- R6: Commit returns `log_ptr` to the base, clears all flags and drops `txn_active`, and keeps all new data. A later transaction logs the same block again.
- R7: Abort with N>0 records holds `busy` high for exactly N cycles. During those cycles it restores the blocks from the newest record to the oldest, then resets the pointer, clears the flags and returns to idle. Abort with no records returns to idle at once and never raises `busy`.
- R8: While `busy` is high, every request is refused (`req_ack`=0) and every command is ignored.
- R9: When LOG_RECS records are already logged, a store that would need a new record is refused without changing data, and `log_full_err` pulses for one cycle. Stores to blocks already written remain accepted.
- R10: When all NTRK tracking entries are in use, an access to an untracked block is refused without effect. Accesses to tracked blocks still succeed.
- R11: Outside a transaction, loads and stores are accepted directly, with no log record and no tracking. Commit and abort are ignored.
- R12: A request presented in the same cycle as `cmd_valid` is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 begin, 10 commit, 11 abort |
| log_base_in | input | PTR_W | Log region byte address, taken on begin |
| req_valid | input | 1 | Load/store request strobe |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | BLK_AW | Block index |
| req_wdata | input | DATA_W | Store data |
| req_ack | output | 1 | Request accepted this cycle |
| rsp_rdata | output | DATA_W | Current contents of block `req_addr` |
| busy | output | 1 | Abort replay in progress |
| txn_active | output | 1 | Transaction open |
| log_ptr | output | PTR_W | Current log pointer |
| log_wr_en | output | 1 | Undo record append strobe |
| log_wr_addr | output | PTR_W | Byte address of the appended record |
| log_wr_tag | output | BLK_AW | Block index stored in the record |
| log_wr_old | output | DATA_W | Old block contents stored in the record |
| log_full_err | output | 1 | One-cycle pulse: store refused, log full |

## Verification
The in-line assertions check several rules on every cycle. Replay refuses all requests, and a command always takes priority over a request in the same cycle. Each record lands exactly one stride below the new pointer. Loads and idle-mode accesses never append. A log-full refusal never coincides with an append. The record count never exceeds capacity. The tracking table never holds two entries for one block. Other behaviours can only be shown by the bench's scenarios, checked against its cycle-by-cycle model: that data after abort equals the pre-transaction values, that replay lasts exactly one cycle per record, that a block is logged once per transaction and again after commit, and how the refusals at the log-capacity and table-capacity limits look at the ports.

// File: rtl/tul_pkg.sv
package tul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TXN  = 2'd1,
        ST_UNDO = 2'd2
    } tul_state_e;

    localparam logic [1:0] TUL_OP_BEGIN  = 2'b01;
    localparam logic [1:0] TUL_OP_COMMIT = 2'b10;
    localparam logic [1:0] TUL_OP_ABORT  = 2'b11;

endpackage

// File: rtl/tul_blk_store.sv
module tul_blk_store #(
    parameter int NBLK   = 16,
    parameter int DATA_W = 512,
    localparam int AW    = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rows_q [NBLK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) rows_q[i] <= '0;
        end else if (we) begin
            rows_q[waddr] <= wdata;
        end
    end

    assign rdata = rows_q[raddr];

endmodule

// File: rtl/tul_log_ram.sv
module tul_log_ram #(
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 512,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [TAG_W-1:0]  wtag,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IW-1:0]     ridx,
    output logic [TAG_W-1:0]  rtag,
    output logic [DATA_W-1:0] rdata
);

    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[widx]  <= wtag;
            data_q[widx] <= wdata;
        end
    end

    assign rtag  = tag_q[ridx];
    assign rdata = data_q[ridx];

endmodule

// File: rtl/tul_track_table.sv
module tul_track_table #(
    parameter int NTRK = 8,
    parameter int AW   = 4,
    localparam int IW  = $clog2(NTRK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic [AW-1:0] lk_addr,
    output logic          hit,
    output logic          hit_wr,
    output logic          room,
    input  logic          upd_en,
    input  logic          upd_rd,
    input  logic          upd_wr
);

    logic [NTRK-1:0] vld_q, rd_q, wr_q;
    logic [AW-1:0]   tag_q [NTRK];
    logic [NTRK-1:0] hit_vec;
    logic [IW-1:0]   free_idx;

    for (genvar g = 0; g < NTRK; g++) begin : g_ent
        assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_addr);

        AST_ENTRY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[g] |-> (rd_q[g] || wr_q[g])); // R3
    end

    assign hit    = |hit_vec;
    assign hit_wr = |(hit_vec & wr_q);

    always_comb begin
        free_idx = '0;
        room     = 1'b0;
        for (int i = NTRK - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_idx = IW'(i);
                room     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
            for (int i = 0; i < NTRK; i++) tag_q[i] <= '0;
        end else if (clr_all) begin
            vld_q <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
        end else if (upd_en) begin
            if (hit) begin
                rd_q <= rd_q | (hit_vec & {NTRK{upd_rd}});
                wr_q <= wr_q | (hit_vec & {NTRK{upd_wr}});
            end else if (room) begin
                vld_q[free_idx] <= 1'b1;
                tag_q[free_idx] <= lk_addr;
                rd_q[free_idx]  <= upd_rd;
                wr_q[free_idx]  <= upd_wr;
            end
        end
    end

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R10

endmodule

// File: rtl/tul_undo_engine.sv
module tul_undo_engine
    import tul_pkg::*;
#(
    parameter int NBLK      = 16,
    parameter int BLK_BYTES = 64,
    parameter int TAG_BYTES = 8,
    parameter int NTRK      = 8,
    parameter int LOG_RECS  = 4,
    parameter int PTR_W     = 32,
    localparam int DATA_W    = BLK_BYTES * 8,
    localparam int BLK_AW    = $clog2(NBLK),
    localparam int REC_BYTES = TAG_BYTES + BLK_BYTES,
    localparam int CNT_W     = $clog2(LOG_RECS + 1),
    localparam int IDX_W     = $clog2(LOG_RECS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PTR_W-1:0]  log_base_in,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [BLK_AW-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              txn_active,
    output logic [PTR_W-1:0]  log_ptr,
    output logic              log_wr_en,
    output logic [PTR_W-1:0]  log_wr_addr,
    output logic [BLK_AW-1:0] log_wr_tag,
    output logic [DATA_W-1:0] log_wr_old,
    output logic              log_full_err
);

    tul_state_e state_q, state_d;

    logic [PTR_W-1:0] ptr_q, base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] uidx_q;
    logic [CNT_W-1:0] cnt_m1;

    logic cmd_begin, cmd_commit, cmd_abort;
    logic in_idle, in_txn, in_undo, undo_last;
    logic trk_hit, trk_hit_wr, trk_room, trk_clr, trk_upd;
    logic need_rec, log_room, alloc_ok, append, full_set;

    logic              ds_we;
    logic [BLK_AW-1:0] ds_waddr;
    logic [DATA_W-1:0] ds_wdata;
    logic [BLK_AW-1:0] lr_tag;
    logic [DATA_W-1:0] lr_data;

    // ---------------- command and request decode ----------------
    assign cmd_begin  = cmd_valid && (cmd_op == TUL_OP_BEGIN);
    assign cmd_commit = cmd_valid && (cmd_op == TUL_OP_COMMIT);
    assign cmd_abort  = cmd_valid && (cmd_op == TUL_OP_ABORT);

    assign in_idle   = (state_q == ST_IDLE);
    assign in_txn    = (state_q == ST_TXN);
    assign in_undo   = (state_q == ST_UNDO);
    assign undo_last = in_undo && (uidx_q == '0);

    assign cnt_m1   = cnt_q - CNT_W'(1);
    assign need_rec = in_txn && req_we && !trk_hit_wr;
    assign log_room = (cnt_q != CNT_W'(LOG_RECS));
    assign alloc_ok = trk_hit || trk_room;

    always_comb begin
        req_ack = 1'b0;
        if (req_valid && !cmd_valid) begin
            unique case (state_q)
                ST_IDLE: req_ack = 1'b1;
                ST_TXN:  req_ack = alloc_ok && (!need_rec || log_room);
                ST_UNDO: req_ack = 1'b0;
                default: req_ack = 1'b0;
            endcase
        end
    end

    assign append   = req_ack && need_rec;
    assign full_set = req_valid && !cmd_valid && need_rec && !log_room;
    assign trk_upd  = req_ack && in_txn;
    assign trk_clr  = (in_idle && cmd_begin) || (in_txn && cmd_commit) ||
                      (in_txn && cmd_abort && (cnt_q == '0)) || undo_last;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_begin) state_d = ST_TXN;
            ST_TXN: begin
                if (cmd_commit)                         state_d = ST_IDLE;
                else if (cmd_abort && (cnt_q == '0))    state_d = ST_IDLE;
                else if (cmd_abort)                     state_d = ST_UNDO;
            end
            ST_UNDO: if (undo_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- log registers and record port ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q        <= '0;
            base_q       <= '0;
            cnt_q        <= '0;
            uidx_q       <= '0;
            log_wr_en    <= 1'b0;
            log_wr_addr  <= '0;
            log_wr_tag   <= '0;
            log_wr_old   <= '0;
            log_full_err <= 1'b0;
        end else begin
            log_wr_en    <= append;
            log_full_err <= full_set;
            if (append) begin
                log_wr_addr <= ptr_q;
                log_wr_tag  <= req_addr;
                log_wr_old  <= rsp_rdata;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_begin) begin
                        base_q <= log_base_in;
                        ptr_q  <= log_base_in;
                        cnt_q  <= '0;
                    end
                end
                ST_TXN: begin
                    if (cmd_commit || (cmd_abort && (cnt_q == '0))) begin
                        ptr_q <= base_q;
                        cnt_q <= '0;
                    end else if (cmd_abort) begin
                        uidx_q <= cnt_m1[IDX_W-1:0];
                    end else if (append) begin
                        ptr_q <= ptr_q + PTR_W'(REC_BYTES);
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_UNDO: begin
                    if (undo_last) begin
                        ptr_q <= base_q;
                        cnt_q <= '0;
                    end else begin
                        uidx_q <= uidx_q - IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy       = 1'b0;
        txn_active = 1'b0;
        ds_we      = req_ack && req_we;
        ds_waddr   = req_addr;
        ds_wdata   = req_wdata;
        unique case (state_q)
            ST_IDLE: ;
            ST_TXN:  txn_active = 1'b1;
            ST_UNDO: begin
                busy     = 1'b1;
                ds_we    = 1'b1;
                ds_waddr = lr_tag;
                ds_wdata = lr_data;
            end
            default: ;
        endcase
    end

    assign log_ptr = ptr_q;

    // ---------------- submodules ----------------
    tul_blk_store #(.NBLK(NBLK), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ds_we),
        .waddr (ds_waddr),
        .wdata (ds_wdata),
        .raddr (req_addr),
        .rdata (rsp_rdata)
    );

    tul_log_ram #(.DEPTH(LOG_RECS), .TAG_W(BLK_AW), .DATA_W(DATA_W)) u_log (
        .clk   (clk),
        .we    (append),
        .widx  (cnt_q[IDX_W-1:0]),
        .wtag  (req_addr),
        .wdata (rsp_rdata),
        .ridx  (uidx_q),
        .rtag  (lr_tag),
        .rdata (lr_data)
    );

    tul_track_table #(.NTRK(NTRK), .AW(BLK_AW)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (trk_clr),
        .lk_addr (req_addr),
        .hit     (trk_hit),
        .hit_wr  (trk_hit_wr),
        .room    (trk_room),
        .upd_en  (trk_upd),
        .upd_rd  (!req_we),
        .upd_wr  (req_we)
    );

    // ---------------- assertions ----------------
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ack); // R8
    AST_CMD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ack); // R12
    AST_LOAD_NO_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_active && req_ack && !req_we) |=> !log_wr_en); // R3
    AST_IDLE_NO_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_active && !busy) |=> !log_wr_en); // R11
    AST_PTR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        log_wr_en |-> (log_ptr == log_wr_addr + PTR_W'(REC_BYTES))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LOG_RECS)); // R9
    AST_FULL_NO_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
        log_full_err |-> !log_wr_en); // R9
    AST_COMMIT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_active && cmd_commit) |=> (log_ptr == base_q && !txn_active && !busy)); // R6

endmodule

// File: tb/tul_undo_engine_tb_top.sv
`timescale 1ns/1ps
module tul_undo_engine_tb_top;

    localparam int NBLK = 16, NTRK = 8, LOGN = 4, DW = 512, AW = 4, REC = 72;
    localparam time TCK = 5ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, req_valid = 0, req_we = 0;
    logic [1:0] cmd_op = '0;
    logic [31:0] log_base_in = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ack, busy, txn_active, log_wr_en, log_full_err;
    logic [DW-1:0] rsp_rdata, log_wr_old;
    logic [31:0] log_ptr, log_wr_addr;
    logic [AW-1:0] log_wr_tag;

    always #(TCK/2) clk = ~clk;

    tul_undo_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .log_base_in(log_base_in), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_rdata(rsp_rdata), .busy(busy), .txn_active(txn_active),
        .log_ptr(log_ptr), .log_wr_en(log_wr_en), .log_wr_addr(log_wr_addr),
        .log_wr_tag(log_wr_tag), .log_wr_old(log_wr_old), .log_full_err(log_full_err)
    );

    int checks = 0, errors = 0;
    string cur_req = "R1";

    typedef struct { int a; logic [DW-1:0] d; } rec_t;
    logic [DW-1:0] m_mem [NBLK];
    rec_t m_log [$];
    int   m_flag [int];
    int   m_st = 0;
    logic [31:0] m_ptr = 0, m_base = 0;
    logic e_wr_en = 0, e_full = 0;
    logic [31:0] e_wr_addr = 0;
    int e_wr_tag = 0;
    logic [DW-1:0] e_wr_old = '0;

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        return {16{32'hC0DE_0000 + k}};
    endfunction

    // one clock: inputs are already set at the falling edge
    task automatic cyc();
        bit ack, present, wrset, need;
        #1;
        ack = 0; present = 0; need = 0;
        if (req_valid && !cmd_valid) begin
            if (m_st == 0) ack = 1;
            else if (m_st == 1) begin
                present = m_flag.exists(int'(req_addr));
                wrset   = present && m_flag[int'(req_addr)][1];
                need    = req_we && !wrset;
                ack     = !(need && m_log.size() == LOGN) && (present || m_flag.num() < NTRK);
            end
        end
        chk("req_ack", DW'(req_ack), DW'(ack));
        chk("rsp_rdata", rsp_rdata, m_mem[req_addr]);
        e_wr_en = 0;
        e_full  = req_valid && !cmd_valid && m_st == 1 && need && m_log.size() == LOGN;
        if (m_st == 2) begin
            rec_t r = m_log.pop_back();
            m_mem[r.a] = r.d;
            if (m_log.size() == 0) begin m_st = 0; m_ptr = m_base; m_flag.delete(); end
        end else if (cmd_valid) begin
            if (m_st == 0 && cmd_op == 2'b01) begin
                m_st = 1; m_base = log_base_in; m_ptr = log_base_in;
                m_flag.delete(); m_log.delete();
            end else if (m_st == 1 && cmd_op == 2'b10) begin
                m_st = 0; m_ptr = m_base; m_flag.delete(); m_log.delete();
            end else if (m_st == 1 && cmd_op == 2'b11) begin
                if (m_log.size() == 0) begin m_st = 0; m_ptr = m_base; m_flag.delete(); end
                else m_st = 2;
            end
        end else if (ack) begin
            if (m_st == 1) begin
                if (need) begin
                    rec_t r; r.a = int'(req_addr); r.d = m_mem[req_addr];
                    m_log.push_back(r);
                    e_wr_en = 1; e_wr_addr = m_ptr; e_wr_tag = r.a; e_wr_old = r.d;
                    m_ptr += REC;
                end
                if (!present) m_flag[int'(req_addr)] = 0;
                m_flag[int'(req_addr)] = m_flag[int'(req_addr)] | (req_we ? 2 : 1);
            end
            if (req_we) m_mem[req_addr] = req_wdata;
        end
        @(posedge clk);
        @(negedge clk);
        chk("busy", DW'(busy), DW'(m_st == 2));
        chk("txn_active", DW'(txn_active), DW'(m_st == 1));
        chk("log_ptr", DW'(log_ptr), DW'(m_ptr));
        chk("log_wr_en", DW'(log_wr_en), DW'(e_wr_en));
        chk("log_full_err", DW'(log_full_err), DW'(e_full));
        if (e_wr_en) begin
            chk("log_wr_addr", DW'(log_wr_addr), DW'(e_wr_addr));
            chk("log_wr_tag", DW'(log_wr_tag), DW'(e_wr_tag));
            chk("log_wr_old", log_wr_old, e_wr_old);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] base = 0);
        cmd_valid = 1; cmd_op = op; log_base_in = base;
        cyc();
        cmd_valid = 0; cmd_op = '0;
    endtask

    task automatic acc(input bit we, input int a, input logic [DW-1:0] d = '0);
        req_valid = 1; req_we = we; req_addr = AW'(a); req_wdata = d;
        cyc();
        req_valid = 0; req_we = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(TCK * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBLK; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        cur_req = "R1";
        chk("busy", DW'(busy), '0);
        chk("txn_active", DW'(txn_active), '0);
        chk("log_ptr", DW'(log_ptr), '0);
        chk("log_wr_en", DW'(log_wr_en), '0);
        chk("log_full_err", DW'(log_full_err), '0);
        acc(0, 3);
        // R11: plain accesses, commit and abort ignored
        cur_req = "R11";
        for (int i = 0; i < NBLK; i++) acc(1, i, pat(i));
        acc(0, 5);
        cmd(2'b10); cmd(2'b11);
        // R2: begin, then begin again ignored
        cur_req = "R2";
        cmd(2'b01, 32'h1000);
        cmd(2'b01, 32'h2000);
        // R3: load marks, no log
        cur_req = "R3";
        acc(0, 0);
        // R4: first stores log with 0x48 stride
        cur_req = "R4";
        acc(1, 12, pat(100));
        acc(1, 4, pat(101));
        // R5: repeat store no record
        cur_req = "R5";
        acc(1, 4, pat(102));
        acc(1, 12, pat(103));
        // R12: request with command
        cur_req = "R12";
        cmd_valid = 1; cmd_op = 2'b01; req_valid = 1; req_we = 1; req_addr = 4'd7; req_wdata = pat(555);
        cyc();
        cmd_valid = 0; req_valid = 0; req_we = 0;
        acc(0, 7);
        // R6: commit keeps data, relogs next time
        cur_req = "R6";
        cmd(2'b10);
        acc(0, 4);
        cmd(2'b01, 32'h0400);
        acc(1, 4, pat(104));
        cmd(2'b10);
        // R7: abort replay of three records
        cur_req = "R7";
        cmd(2'b01, 32'h3000);
        acc(1, 1, pat(201));
        acc(1, 2, pat(202));
        acc(1, 1, pat(203));
        acc(1, 3, pat(204));
        cmd(2'b11);
        // R8: requests and commands during replay
        cur_req = "R8";
        acc(1, 9, pat(300));
        cmd(2'b10);
        cur_req = "R7";
        idle(2);
        acc(0, 1); acc(0, 2); acc(0, 3);
        // R7: empty abort
        cmd(2'b01, 32'h3000);
        acc(0, 6);
        cmd(2'b11);
        // R9: log full
        cur_req = "R9";
        cmd(2'b01, 32'h1000);
        for (int i = 8; i < 12; i++) acc(1, i, pat(400 + i));
        acc(1, 13, pat(499));
        acc(0, 13);
        acc(1, 9, pat(498));
        acc(0, 14);
        cur_req = "R7";
        cmd(2'b11);
        idle(5);
        acc(0, 8); acc(0, 11);
        // R10: tracking table full
        cur_req = "R10";
        cmd(2'b01, 32'h5000);
        for (int i = 0; i < NTRK; i++) acc(0, i);
        acc(0, 8);
        acc(1, 9, pat(600));
        acc(0, 2);
        acc(1, 2, pat(601));
        cmd(2'b10);
        acc(0, 9);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule